// File: doc/BRIEF.md
# Index Prefix Decoder

This block sits at the front of an instruction decode path. It takes an opcode stream one byte at a time and follows the two index prefixes, 0xDD and 0xFD. It reports one result for each instruction. The result gives the 16-bit pointer the instruction works through (HL, IX or IY), whether a signed displacement byte came with it, the sign-extended displacement, the final opcode byte, and the opcode page that byte belongs to (main, bit-operation 0xCB or extended 0xED). It also flags a prefix that had no effect. When several prefixes arrive in a row, each one that is overtaken produces a separate NOP strobe, so that later stages can charge refresh and timing for it.

The rewriting is deliberately narrow. Only the pointer role of HL is replaced. An opcode that reads or writes memory at HL becomes an access at the index register plus a displacement, and the opcode byte itself is passed through unchanged. For an opcode such as 0x66, that means the H or L named as the second operand stays plain H or L. The jump through HL becomes a jump to the index register and takes no displacement. The bench assumes that immediate and address operand bytes are taken by the executing stage and never presented on `byte_i`. Executing the instruction is not part of this block.

Top module: `idx_prefix_dec`

## Requirements
- R1: After reset both strobes are low, `ptr_sel_o`=0, `page_o`=0, and `has_disp_o`, `disp_o`, `opc_o` and `pfx_ign_o` are zero.
- R2: An unprefixed byte that is not 0xDD, 0xFD, 0xCB or 0xED produces `insn_vld_o` for one cycle, in the cycle after that byte is accepted, with `ptr_sel_o`=0 (HL), `page_o`=0 (main), `has_disp_o`=0 and `pfx_ign_o`=0.
- R3: After a prefix, the opcodes that use HL as a register pair (0x09, 0x19, 0x29, 0x39, 0x21, 0x22, 0x2A, 0x23, 0x2B, 0xE1, 0xE3, 0xE5, 0xF9) strobe right away with `ptr_sel_o`=1 for 0xDD or 2 for 0xFD, and `has_disp_o`=0.
- R4: After a prefix, a memory-at-HL opcode (0x34, 0x35, 0x36; 0x40–0x7F except 0x76 when bits [2:0] or [5:3] equal 6; 0x80–0xBF when bits [2:0] equal 6) waits for one more byte, the displacement. The strobe follows that byte with `has_disp_o`=1, the index pointer, `disp_o` equal to the displacement sign-extended to `DISP_W` bits, and `opc_o` equal to the original opcode, so H and L operands are kept.
- R5: 0xE9 after a prefix strobes at once with the index pointer and `has_disp_o`=0.
- R6: After a prefix, any other main-page opcode, including 0xEB and 0xD9, strobes with `ptr_sel_o`=0 and `pfx_ign_o`=1.
- R7: A 0xCB or 0xED byte with no prefix before it selects page 1 or page 2 for the next byte, which strobes with pointer HL. A 0xED after a prefix does the same and also sets `pfx_ign_o`=1.
- R8: When a prefix follows a prefix, `nop_vld_o` pulses in the cycle after the later prefix is accepted. Only the last prefix applies to the instruction.
- R9: Prefix, 0xCB, displacement, opcode: the strobe follows the fourth byte with `page_o`=1, the index pointer, `has_disp_o`=1 and the sign-extended displacement.
- R10: `insn_vld_o` and `nop_vld_o` are never high together, and each is high only in the cycle after a byte is accepted.
- R11: Cycles with `byte_vld_i` low leave the decode state and all outputs unchanged, and no strobe follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Stream byte |
| byte_vld_i | input | 1 | `byte_i` is valid this cycle |
| insn_vld_o | output | 1 | Decoded instruction strobe |
| nop_vld_o | output | 1 | Superseded prefix strobe |
| ptr_sel_o | output | 2 | Pointer: 0 HL, 1 IX, 2 IY |
| has_disp_o | output | 1 | A displacement came with the instruction |
| disp_o | output | DISP_W | Sign-extended displacement, zero when absent |
| opc_o | output | 8 | Final opcode byte |
| page_o | output | 2 | Page: 0 main, 1 bit-operation, 2 extended |
| pfx_ign_o | output | 1 | A prefix was present but had no effect |

## Verification
The assertions assume that `byte_i` carries only prefix, page, opcode and displacement bytes, and that every displacement arrives in the slot its opcode calls for. They further assume that `byte_vld_i` is low while reset is held. The bench builds its stimulus from whole instructions: random runs of prefixes, then an opcode taken from one of the rewrite classes, then the bytes that class needs. Random idle gaps are placed between bytes, so the stream never gets out of step with the decoder.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam logic [7:0] PFX_IX = 8'hDD;
  localparam logic [7:0] PFX_IY = 8'hFD;
  localparam logic [7:0] PG_BIT = 8'hCB;
  localparam logic [7:0] PG_EXT = 8'hED;

  typedef enum logic [1:0] {PTR_HL = 2'd0, PTR_IX = 2'd1, PTR_IY = 2'd2} ptr_e;
  typedef enum logic [1:0] {PAGE_MAIN = 2'd0, PAGE_BIT = 2'd1, PAGE_EXT = 2'd2} page_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PFX, ST_BIT, ST_EXT, ST_DISP, ST_BDISP, ST_BOPC
  } st_e;

  typedef struct packed {
    logic [1:0] ptr;
    logic       has_disp;
    logic [7:0] disp;
    logic [7:0] opc;
    logic [1:0] page;
    logic       ign;
  } res_t;
endpackage

// File: rtl/idx_opc_class.sv
module idx_opc_class
  import idx_pkg::*;
(
  input  logic [7:0] op_i,
  output logic       is_pfx_o,
  output logic       is_bit_o,
  output logic       is_ext_o,
  output logic       uses_mem_o,
  output logic       uses_pair_o
);
  logic ld_grp, alu_grp;

  assign is_pfx_o = (op_i == PFX_IX) || (op_i == PFX_IY);
  assign is_bit_o = (op_i == PG_BIT);
  assign is_ext_o = (op_i == PG_EXT);

  // 0x40..0x7F loads, halt (0x76) has no memory form
  assign ld_grp  = (op_i[7:6] == 2'b01) && (op_i != 8'h76) &&
                   ((op_i[2:0] == 3'd6) || (op_i[5:3] == 3'd6));
  assign alu_grp = (op_i[7:6] == 2'b10) && (op_i[2:0] == 3'd6);

  always_comb begin
    uses_mem_o = ld_grp || alu_grp;
    case (op_i)
      8'h34, 8'h35, 8'h36: uses_mem_o = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (op_i)
      8'h09, 8'h19, 8'h29, 8'h39,
      8'h21, 8'h22, 8'h2A, 8'h23, 8'h2B,
      8'hE1, 8'hE3, 8'hE5, 8'hE9, 8'hF9: uses_pair_o = 1'b1;
      default:                            uses_pair_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/idx_seq.sv
module idx_seq
  import idx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] byte_i,
  input  logic       byte_vld_i,
  input  logic       is_pfx_i,
  input  logic       is_bit_i,
  input  logic       is_ext_i,
  input  logic       uses_mem_i,
  input  logic       uses_pair_i,
  output logic       insn_vld_o,
  output logic       nop_vld_o,
  output res_t       res_o
);
  st_e        st_q, st_d;
  ptr_e       sel_q, sel_d;
  logic       ign_q, ign_d;
  logic [7:0] opc_q, opc_d;
  logic [7:0] dsp_q, dsp_d;
  logic       emit, nop;
  res_t       res_d, res_q;
  logic       insn_q, nop_q;
  ptr_e       pfx_sel;

  assign pfx_sel = (byte_i == PFX_IX) ? PTR_IX : PTR_IY;

  always_comb begin
    st_d  = st_q;
    sel_d = sel_q;
    ign_d = ign_q;
    opc_d = opc_q;
    dsp_d = dsp_q;
    emit  = 1'b0;
    nop   = 1'b0;
    res_d = '{ptr: PTR_HL, has_disp: 1'b0, disp: 8'h00, opc: byte_i,
              page: PAGE_MAIN, ign: 1'b0};
    if (byte_vld_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (is_pfx_i) begin
            sel_d = pfx_sel;
            st_d  = ST_PFX;
          end else if (is_bit_i) begin
            ign_d = 1'b0;
            st_d  = ST_BIT;
          end else if (is_ext_i) begin
            ign_d = 1'b0;
            st_d  = ST_EXT;
          end else begin
            emit = 1'b1;
          end
        end
        ST_PFX: begin
          if (is_pfx_i) begin
            nop   = 1'b1;
            sel_d = pfx_sel;
          end else if (is_bit_i) begin
            st_d = ST_BDISP;
          end else if (is_ext_i) begin
            ign_d = 1'b1;
            st_d  = ST_EXT;
          end else if (uses_mem_i) begin
            opc_d = byte_i;
            st_d  = ST_DISP;
          end else begin
            emit = 1'b1;
            st_d = ST_IDLE;
            if (uses_pair_i) res_d.ptr = sel_q;
            else             res_d.ign = 1'b1;
          end
        end
        ST_DISP: begin
          emit           = 1'b1;
          res_d.ptr      = sel_q;
          res_d.has_disp = 1'b1;
          res_d.disp     = byte_i;
          res_d.opc      = opc_q;
          st_d           = ST_IDLE;
        end
        ST_BDISP: begin
          dsp_d = byte_i;
          st_d  = ST_BOPC;
        end
        ST_BOPC: begin
          emit           = 1'b1;
          res_d.ptr      = sel_q;
          res_d.has_disp = 1'b1;
          res_d.disp     = dsp_q;
          res_d.page     = PAGE_BIT;
          st_d           = ST_IDLE;
        end
        ST_BIT: begin
          emit       = 1'b1;
          res_d.page = PAGE_BIT;
          st_d       = ST_IDLE;
        end
        ST_EXT: begin
          emit       = 1'b1;
          res_d.page = PAGE_EXT;
          res_d.ign  = ign_q;
          st_d       = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= PTR_HL;
      ign_q  <= 1'b0;
      opc_q  <= 8'h00;
      dsp_q  <= 8'h00;
      insn_q <= 1'b0;
      nop_q  <= 1'b0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      ign_q  <= ign_d;
      opc_q  <= opc_d;
      dsp_q  <= dsp_d;
      insn_q <= emit;
      nop_q  <= nop;
      if (emit) res_q <= res_d;
    end
  end

  assign insn_vld_o = insn_q;
  assign nop_vld_o  = nop_q;
  assign res_o      = res_q;
endmodule

// File: rtl/idx_prefix_dec.sv
module idx_prefix_dec
  import idx_pkg::*;
#(
  parameter int DISP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        byte_i,
  input  logic              byte_vld_i,
  output logic              insn_vld_o,
  output logic              nop_vld_o,
  output logic [1:0]        ptr_sel_o,
  output logic              has_disp_o,
  output logic [DISP_W-1:0] disp_o,
  output logic [7:0]        opc_o,
  output logic [1:0]        page_o,
  output logic              pfx_ign_o
);
  logic is_pfx, is_bit, is_ext, uses_mem, uses_pair;
  res_t res;

  idx_opc_class u_class (
    .op_i       (byte_i),
    .is_pfx_o   (is_pfx),
    .is_bit_o   (is_bit),
    .is_ext_o   (is_ext),
    .uses_mem_o (uses_mem),
    .uses_pair_o(uses_pair)
  );

  idx_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (byte_i),
    .byte_vld_i (byte_vld_i),
    .is_pfx_i   (is_pfx),
    .is_bit_i   (is_bit),
    .is_ext_i   (is_ext),
    .uses_mem_i (uses_mem),
    .uses_pair_i(uses_pair),
    .insn_vld_o (insn_vld_o),
    .nop_vld_o  (nop_vld_o),
    .res_o      (res)
  );

  assign ptr_sel_o  = res.ptr;
  assign has_disp_o = res.has_disp;
  assign opc_o      = res.opc;
  assign page_o     = res.page;
  assign pfx_ign_o  = res.ign;

  generate
    if (DISP_W > 8) begin : g_sext
      localparam int EXT_W = DISP_W - 8;
      assign disp_o = {{EXT_W{res.disp[7]}}, res.disp};
    end else begin : g_trunc
      assign disp_o = res.disp[DISP_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/idx_prefix_dec_chk.sv
module idx_prefix_dec_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] byte_i,
  input logic       byte_vld_i,
  input logic       insn_vld_o,
  input logic       nop_vld_o,
  input logic [1:0] ptr_sel_o,
  input logic       has_disp_o,
  input logic [7:0] opc_o,
  input logic [1:0] page_o,
  input logic       pfx_ign_o
);
  a_r10_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(insn_vld_o && nop_vld_o));

  a_r10_strobe_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_vld_o || nop_vld_o) |-> $past(byte_vld_i));

  a_r8_nop_after_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_vld_o |-> ($past(byte_i) == 8'hDD || $past(byte_i) == 8'hFD));

  a_r4_disp_means_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_vld_o && has_disp_o) |-> (ptr_sel_o != 2'd0));

  a_r6_ignored_means_hl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_vld_o && pfx_ign_o) |-> (ptr_sel_o == 2'd0));

  a_r7_ext_page_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_vld_o && page_o == 2'd2) |-> (!has_disp_o && ptr_sel_o == 2'd0));

  a_r9_bit_index_disp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_vld_o && page_o == 2'd1 && ptr_sel_o != 2'd0) |-> has_disp_o);

  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld_i |=> (!insn_vld_o && !nop_vld_o && $stable(opc_o) &&
                     $stable(ptr_sel_o) && $stable(page_o)));
endmodule

bind idx_prefix_dec idx_prefix_dec_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .byte_i    (byte_i),
  .byte_vld_i(byte_vld_i),
  .insn_vld_o(insn_vld_o),
  .nop_vld_o (nop_vld_o),
  .ptr_sel_o (ptr_sel_o),
  .has_disp_o(has_disp_o),
  .opc_o     (opc_o),
  .page_o    (page_o),
  .pfx_ign_o (pfx_ign_o)
);

// File: tb/idx_prefix_dec_bench.sv
`timescale 1ns/1ps
module idx_prefix_dec_bench;
  localparam int DISP_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [7:0]        byte_i = 8'h00;
  logic              byte_vld_i = 1'b0;
  logic              insn_vld_o, nop_vld_o, has_disp_o, pfx_ign_o;
  logic [1:0]        ptr_sel_o, page_o;
  logic [DISP_W-1:0] disp_o;
  logic [7:0]        opc_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #4 clk_i = ~clk_i;

  idx_prefix_dec #(.DISP_W(DISP_W)) u_idx_prefix_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .byte_vld_i(byte_vld_i),
    .insn_vld_o(insn_vld_o), .nop_vld_o(nop_vld_o), .ptr_sel_o(ptr_sel_o),
    .has_disp_o(has_disp_o), .disp_o(disp_o), .opc_o(opc_o), .page_o(page_o),
    .pfx_ign_o(pfx_ign_o)
  );

  function automatic bit f_mem(input logic [7:0] op);
    if (op == 8'h34 || op == 8'h35 || op == 8'h36) return 1;
    if (op >= 8'h40 && op <= 8'h7F && op != 8'h76 &&
        (op[2:0] == 3'd6 || op[5:3] == 3'd6)) return 1;
    if (op >= 8'h80 && op <= 8'hBF && op[2:0] == 3'd6) return 1;
    return 0;
  endfunction

  function automatic bit f_pair(input logic [7:0] op);
    return op inside {8'h09, 8'h19, 8'h29, 8'h39, 8'h21, 8'h22, 8'h2A, 8'h23,
                      8'h2B, 8'hE1, 8'hE3, 8'hE5, 8'hE9, 8'hF9};
  endfunction

  function automatic bit f_pfx(input logic [7:0] op);
    return op == 8'hDD || op == 8'hFD;
  endfunction

  function automatic logic [DISP_W-1:0] f_sext(input logic [7:0] d);
    return {{(DISP_W-8){d[7]}}, d};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_gap();
    int n = $urandom % 3;
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk(!insn_vld_o && !nop_vld_o, "R11", "strobe in idle cycle",
          {insn_vld_o, nop_vld_o}, 0);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit e_ins, input bit e_nop,
                     input string req);
    byte_i = b; byte_vld_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    byte_vld_i = 1'b0;
    byte_i = $urandom;
    chk(insn_vld_o == e_ins && nop_vld_o == e_nop, req, "strobes",
        {insn_vld_o, nop_vld_o}, {e_ins, e_nop});
  endtask

  task automatic fields(input logic [1:0] ptr, input bit hd,
                        input logic [DISP_W-1:0] d, input logic [7:0] op,
                        input logic [1:0] pg, input bit ign, input string req);
    chk(ptr_sel_o == ptr, req, "ptr_sel", ptr_sel_o, ptr);
    chk(has_disp_o == hd, req, "has_disp", has_disp_o, hd);
    chk(disp_o == d, req, "disp", disp_o, d);
    chk(opc_o == op, req, "opc", opc_o, op);
    chk(page_o == pg, req, "page", page_o, pg);
    chk(pfx_ign_o == ign, req, "pfx_ign", pfx_ign_o, ign);
  endtask

  // one instruction: npfx prefixes ending in lastp, then op with b2/b3 as needed
  task automatic run_insn(input int npfx, input logic [7:0] lastp,
                          input logic [7:0] op, input logic [7:0] b2,
                          input logic [7:0] b3);
    logic [1:0] sel;
    for (int i = 0; i < npfx; i++) begin
      logic [7:0] p = (i == npfx - 1) ? lastp : (($urandom % 2) ? 8'hDD : 8'hFD);
      put(p, 0, i > 0, "R8");
      idle_gap();
    end
    sel = (lastp == 8'hDD) ? 2'd1 : 2'd2;
    if (npfx == 0) begin
      if (op == 8'hCB || op == 8'hED) begin
        put(op, 0, 0, "R7"); idle_gap();
        put(b2, 1, 0, "R7");
        fields(2'd0, 0, '0, b2, (op == 8'hCB) ? 2'd1 : 2'd2, 0, "R7");
      end else begin
        put(op, 1, 0, "R2");
        fields(2'd0, 0, '0, op, 2'd0, 0, "R2");
      end
    end else if (op == 8'hCB) begin
      put(op, 0, 0, "R9"); idle_gap();
      put(b2, 0, 0, "R9"); idle_gap();
      put(b3, 1, 0, "R9");
      fields(sel, 1, f_sext(b2), b3, 2'd1, 0, "R9");
    end else if (op == 8'hED) begin
      put(op, 0, 0, "R7"); idle_gap();
      put(b2, 1, 0, "R7");
      fields(2'd0, 0, '0, b2, 2'd2, 1, "R7");
    end else if (f_mem(op)) begin
      put(op, 0, 0, "R4"); idle_gap();
      put(b2, 1, 0, "R4");
      fields(sel, 1, f_sext(b2), op, 2'd0, 0, "R4");
    end else if (f_pair(op)) begin
      put(op, 1, 0, (op == 8'hE9) ? "R5" : "R3");
      fields(sel, 0, '0, op, 2'd0, 0, (op == 8'hE9) ? "R5" : "R3");
    end else begin
      put(op, 1, 0, "R6");
      fields(2'd0, 0, '0, op, 2'd0, 1, "R6");
    end
    idle_gap();
  endtask

  initial begin
    void'($urandom(32'h1d5eed));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(!insn_vld_o && !nop_vld_o, "R1", "strobes", {insn_vld_o, nop_vld_o}, 0);
    fields(2'd0, 0, '0, 8'h00, 2'd0, 0, "R1");

    // directed corners
    run_insn(0, 8'hDD, 8'h3E, 0, 0);            // R2
    run_insn(1, 8'hDD, 8'h21, 0, 0);            // R3 IX
    run_insn(1, 8'hFD, 8'h29, 0, 0);            // R3 IY
    run_insn(1, 8'hDD, 8'h66, 8'h80, 0);        // R4 H kept, negative disp
    run_insn(1, 8'hFD, 8'h75, 8'h7F, 0);        // R4 L kept, max positive
    run_insn(1, 8'hDD, 8'h36, 8'hFF, 0);        // R4
    run_insn(1, 8'hFD, 8'hE9, 0, 0);            // R5
    run_insn(1, 8'hDD, 8'hEB, 0, 0);            // R6 exchange DE,HL
    run_insn(1, 8'hFD, 8'hD9, 0, 0);            // R6 exchange all
    run_insn(1, 8'hDD, 8'h76, 0, 0);            // R6 halt not memory
    run_insn(1, 8'hDD, 8'hED, 8'h44, 0);        // R7 prefixed ext page
    run_insn(0, 8'hDD, 8'hCB, 8'h37, 0);        // R7 plain bit page
    run_insn(3, 8'hFD, 8'h23, 0, 0);            // R8 last prefix wins
    run_insn(2, 8'hDD, 8'hCB, 8'h80, 8'h06);    // R9
    run_insn(1, 8'hFD, 8'hCB, 8'h01, 8'h00);    // R9

    // constrained random instructions
    for (int k = 0; k < 600; k++) begin
      int         np   = $urandom % 4;
      logic [7:0] lp   = ($urandom % 2) ? 8'hDD : 8'hFD;
      logic [7:0] op   = $urandom;
      int         mode = $urandom % 5;
      if (np > 0) begin
        case (mode)
          0: op = 8'hCB;
          1: op = 8'hED;
          2: while (!f_mem(op)) op = $urandom;
          3: while (!f_pair(op)) op = $urandom;
          default: while (f_pfx(op)) op = $urandom;
        endcase
      end else begin
        while (f_pfx(op)) op = $urandom;
      end
      run_insn(np, lp, op, $urandom, $urandom);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule